// File: doc/BRIEF.md
# Integer and Single-Precision Float Conversion Unit

This unit converts a 32-bit operand in either direction between signed two's-complement integers and IEEE-754 single-precision numbers. Each accepted operand carries an operation select and a 2-bit rounding-mode code. The code decides how a result that cannot be represented exactly is rounded. The same rounding-decision logic serves both directions. The unit reports two flags with every result. The invalid flag marks a float-to-integer conversion that had to saturate. The inexact flag marks a result that lost precision during rounding.

An operand is presented together with `in_valid`. Its result, the invalid flag and the inexact flag appear on the outputs one clock later, with `out_valid` high for that cycle. Back-to-back operands give back-to-back results. A small two-state controller tracks whether a result is being emitted. In ST_IDLE nothing is emitted. In ST_EMIT a result is on the outputs. The controller has four transitions:
- accept: ST_IDLE to ST_EMIT when `in_valid` is high.
- wait: ST_IDLE to ST_IDLE when `in_valid` is low.
- stream: ST_EMIT to ST_EMIT when `in_valid` is high.
- drain: ST_EMIT to ST_IDLE when `in_valid` is low.

Top module: `fcvt_unit`

## Requirements
- R1: After reset, `out_valid`, `out_data`, `out_invalid` and `out_inexact` are all 0. `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high.
- R2: For integer-to-float conversion (`in_op` = 0), any integer whose magnitude is at most 2^24 converts exactly with `out_inexact` = 0, and zero converts to 0x00000000.
- R3: For integer-to-float conversion, larger magnitudes are rounded to 24 significant bits, and `out_inexact` is set when discarded bits were nonzero. The rounding mode on `in_rm` is decoded as follows:
  - code 0: nearest, ties to even.
  - code 1: toward zero.
  - code 2: toward +infinity.
  - code 3: toward -infinity.
- R4: For float-to-integer conversion (`in_op` = 1), a finite in-range operand yields the signed integer rounded by the `in_rm` code. `out_inexact` = 1 when the operand had a nonzero fraction.
- R5: For float-to-integer conversion, a NaN of either sign yields 0x7FFFFFFF with `out_invalid` = 1.
- R6: For float-to-integer conversion, an infinity, or a finite value outside [-2^31, 2^31-1], saturates to 0x7FFFFFFF when positive and 0x80000000 when negative, with `out_invalid` = 1 and `out_inexact` = 0. The value -2^31 converts exactly without the invalid flag.
- R7: For float-to-integer conversion, zero and subnormal operands yield 0. There are two exceptions: a positive nonzero subnormal under code 2 yields 1, and a negative nonzero subnormal under code 3 yields 0xFFFFFFFF. A nonzero subnormal always sets `out_inexact`.
- R8: Integer-to-float conversion never raises `out_invalid`.
- R9: In cycles without `in_valid`, `out_data`, `out_invalid` and `out_inexact` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 1 | 0 = integer to float, 1 = float to integer |
| in_rm | input | 2 | Rounding-mode code (0 nearest-even, 1 toward zero, 2 up, 3 down) |
| in_data | input | 32 | Operand |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 32 | Converted result |
| out_invalid | output | 1 | Saturation on NaN or out-of-range float |
| out_inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The assertions assume that `in_op`, `in_rm` and `in_data` are driven to known values whenever `in_valid` is high. They also assume that the operand is meant as a float exactly when `in_op` is 1. No ordering or spacing between strobes is assumed. The stimulus drives every input away from the sampling edge and keeps all fields defined at all times. It mixes directed corner values with pseudo-random operands, in both bursts and single strobes separated by idle gaps. The corner values are:
- ties at the 24-bit boundary,
- the most negative integer,
- NaNs and infinities,
- the exact -2^31 float,
- subnormals.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'd0,
        RM_TRUNC     = 2'd1,
        RM_CEIL      = 2'd2,
        RM_FLOOR     = 2'd3
    } rmode_e;

    typedef enum logic {
        OP_INT_TO_FP = 1'b0,
        OP_FP_TO_INT = 1'b1
    } cvt_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } cvt_state_e;

    // Everything the rounding decision needs from either datapath.
    typedef struct packed {
        logic neg;
        logic lsb;
        logic guard;
        logic sticky;
    } rnd_info_t;

endpackage

// File: rtl/fcvt_round.sv
module fcvt_round
    import fcvt_pkg::*;
(
    input  rmode_e    rm,
    input  rnd_info_t info,
    output logic      inc
);

    logic lost;

    always_comb begin
        lost = info.guard | info.sticky;
        unique case (rm)
            RM_NEAR_EVEN: inc = info.guard & (info.sticky | info.lsb);
            RM_TRUNC:     inc = 1'b0;
            RM_CEIL:      inc = ~info.neg & lost;
            RM_FLOOR:     inc = info.neg & lost;
            default:      inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/fcvt_i2f.sv
module fcvt_i2f
    import fcvt_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [INT_W-1:0] src,
    input  logic             inc,
    output rnd_info_t        rnd,
    output logic [INT_W-1:0] res,
    output logic             inexact
);

    localparam int SIG_W   = MAN_W + 1;
    localparam int LZ_W    = $clog2(INT_W) + 1;
    localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
    localparam int TOP_EXP = BIAS + INT_W - 1;
    localparam int LOW_W   = INT_W - SIG_W - 1;

    logic             neg;
    logic [INT_W-1:0] mag;
    logic [INT_W-1:0] norm;
    logic [LZ_W-1:0]  lz;
    logic [SIG_W-1:0] kept;
    logic             guard;
    logic             sticky;
    logic [SIG_W:0]   sum;
    logic [EXP_W-1:0] exp_base;
    logic [EXP_W-1:0] exp_fin;
    logic [MAN_W-1:0] frac;

    // Magnitude and normalisation: leading one moved to the top bit.
    always_comb begin
        neg = src[INT_W-1];
        mag = neg ? (~src + INT_W'(1)) : src;
        lz  = LZ_W'(INT_W);
        for (int i = 0; i < INT_W; i++) begin
            if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
        end
        norm   = mag << lz;
        kept   = norm[INT_W-1 -: SIG_W];
        guard  = norm[LOW_W];
        sticky = |norm[LOW_W-1:0];
        rnd    = '{neg: neg, lsb: kept[0], guard: guard, sticky: sticky};
    end

    // Apply the increment and pack.
    always_comb begin
        sum      = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
        exp_base = EXP_W'(TOP_EXP) - EXP_W'(lz);
        if (sum[SIG_W]) begin
            exp_fin = exp_base + EXP_W'(1);
            frac    = '0;
        end else begin
            exp_fin = exp_base;
            frac    = sum[MAN_W-1:0];
        end
        if (mag == '0) begin
            res     = '0;
            inexact = 1'b0;
        end else begin
            res     = INT_W'({neg, exp_fin, frac});
            inexact = guard | sticky;
        end
    end

endmodule

// File: rtl/fcvt_f2i.sv
module fcvt_f2i
    import fcvt_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic [INT_W-1:0] src,
    input  logic             inc,
    output rnd_info_t        rnd,
    output logic [INT_W-1:0] res,
    output logic             invalid,
    output logic             inexact
);

    localparam int SIG_W     = MAN_W + 1;
    localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
    localparam int ZERO_EXP  = BIAS + MAN_W;
    localparam int LIMIT_EXP = BIAS + INT_W - 1;
    localparam int EXT_W     = 2 * SIG_W + 1;
    localparam logic [INT_W-1:0] INT_MAX = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] INT_MIN = {1'b1, {(INT_W-1){1'b0}}};

    typedef enum logic [2:0] {
        CL_NAN, CL_SAT, CL_MIN, CL_WHOLE, CL_FRAC
    } f_class_e;

    logic             sign;
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] f;
    logic [EXP_W-1:0] e_eff;
    logic [SIG_W-1:0] sig;
    logic [EXP_W-1:0] sh;
    logic [EXT_W-1:0] ext;
    logic [SIG_W-1:0] int_part;
    logic             guard;
    logic             sticky;
    f_class_e         cls;
    logic [INT_W-1:0] mag;

    // Classification and fraction split.
    always_comb begin
        sign     = src[EXP_W+MAN_W];
        e        = src[EXP_W+MAN_W-1:MAN_W];
        f        = src[MAN_W-1:0];
        e_eff    = (e == '0) ? EXP_W'(1) : e;
        sig      = {(e != '0), f};
        sh       = EXP_W'(ZERO_EXP) - e_eff;
        ext      = {sig, {(SIG_W+1){1'b0}}} >> sh;
        int_part = '0;
        guard    = 1'b0;
        sticky   = 1'b0;
        if (e == {EXP_W{1'b1}}) begin
            cls = (f != '0) ? CL_NAN : CL_SAT;
        end else if (e >= EXP_W'(LIMIT_EXP)) begin
            cls = (sign && e == EXP_W'(LIMIT_EXP) && f == '0) ? CL_MIN : CL_SAT;
        end else if (e >= EXP_W'(ZERO_EXP)) begin
            cls = CL_WHOLE;
        end else begin
            cls = CL_FRAC;
            if (int'(sh) > SIG_W) begin
                sticky = |sig;
            end else begin
                int_part = ext[EXT_W-1 -: SIG_W];
                guard    = ext[SIG_W];
                sticky   = |ext[SIG_W-1:0];
            end
        end
        rnd = '{neg: sign, lsb: int_part[0], guard: guard, sticky: sticky};
    end

    // Result assembly with the rounding increment.
    always_comb begin
        mag     = '0;
        res     = '0;
        invalid = 1'b0;
        inexact = 1'b0;
        unique case (cls)
            CL_NAN: begin
                invalid = 1'b1;
                res     = INT_MAX;
            end
            CL_SAT: begin
                invalid = 1'b1;
                res     = sign ? INT_MIN : INT_MAX;
            end
            CL_MIN: begin
                res = INT_MIN;
            end
            CL_WHOLE: begin
                mag = INT_W'(sig) << (e - EXP_W'(ZERO_EXP));
                res = sign ? (~mag + INT_W'(1)) : mag;
            end
            CL_FRAC: begin
                mag     = INT_W'(int_part) + INT_W'(inc);
                res     = sign ? (~mag + INT_W'(1)) : mag;
                inexact = guard | sticky;
            end
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
    import fcvt_pkg::*;
#(
    parameter int INT_W = 32,
    parameter int EXP_W = 8,
    parameter int MAN_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_op,
    input  logic [1:0]       in_rm,
    input  logic [INT_W-1:0] in_data,
    output logic             out_valid,
    output logic [INT_W-1:0] out_data,
    output logic             out_invalid,
    output logic             out_inexact
);

    localparam logic [INT_W-1:0] SAT_POS = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] SAT_NEG = {1'b1, {(INT_W-1){1'b0}}};

    cvt_op_e    op;
    rmode_e     rm;
    cvt_state_e state_q, state_d;

    rnd_info_t        i2f_rnd, f2i_rnd, rnd_sel;
    logic             inc;
    logic [INT_W-1:0] i2f_res, f2i_res, res_d;
    logic             i2f_inex, f2i_inex, f2i_inv;
    logic             inv_d, inex_d;

    assign op = cvt_op_e'(in_op);
    assign rm = rmode_e'(in_rm);

    fcvt_i2f #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_i2f (
        .src     (in_data),
        .inc     (inc),
        .rnd     (i2f_rnd),
        .res     (i2f_res),
        .inexact (i2f_inex)
    );

    fcvt_f2i #(.INT_W(INT_W), .EXP_W(EXP_W), .MAN_W(MAN_W)) u_f2i (
        .src     (in_data),
        .inc     (inc),
        .rnd     (f2i_rnd),
        .res     (f2i_res),
        .invalid (f2i_inv),
        .inexact (f2i_inex)
    );

    // One rounding decision, fed by whichever direction is selected.
    assign rnd_sel = (op == OP_INT_TO_FP) ? i2f_rnd : f2i_rnd;

    fcvt_round u_round (
        .rm   (rm),
        .info (rnd_sel),
        .inc  (inc)
    );

    always_comb begin
        if (op == OP_INT_TO_FP) begin
            res_d  = i2f_res;
            inv_d  = 1'b0;
            inex_d = i2f_inex;
        end else begin
            res_d  = f2i_res;
            inv_d  = f2i_inv;
            inex_d = f2i_inex;
        end
    end

    // Next-state logic: accept, wait, stream, drain.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_EMIT : ST_IDLE;
            ST_EMIT: state_d = in_valid ? ST_EMIT : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data    <= '0;
            out_invalid <= 1'b0;
            out_inexact <= 1'b0;
        end else if (in_valid) begin
            out_data    <= res_d;
            out_invalid <= inv_d;
            out_inexact <= inex_d;
        end
    end

    assign out_valid = (state_q == ST_EMIT);

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_quiet_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_no_invalid_i2f_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 1'b0) |=> !out_invalid);
    assert_nan_saturates_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 1'b1 && in_data[INT_W-2 -: EXP_W] == {EXP_W{1'b1}}
         && in_data[MAN_W-1:0] != '0) |=> (out_invalid && out_data == SAT_POS));
    assert_invalid_is_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_invalid |-> (out_data == SAT_POS || out_data == SAT_NEG));
    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));

endmodule

// File: tb/tb_fcvt_unit.sv
module tb_fcvt_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_op;
    logic [1:0]  in_rm;
    logic [31:0] in_data;
    logic        out_valid;
    logic [31:0] out_data;
    logic        out_invalid;
    logic        out_inexact;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;

    always #10 clk = ~clk;

    fcvt_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_rm(in_rm), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data), .out_invalid(out_invalid), .out_inexact(out_inexact)
    );

    // Reference model state
    bit          m_valid;
    logic [31:0] m_data;
    bit          m_inv;
    bit          m_inex;
    string       m_tag;

    function automatic bit round_up(input bit neg, input bit odd, input bit gt,
                                    input bit eq, input bit nz, input logic [1:0] rm);
        case (rm)
            2'd0:    return gt || (eq && odd);
            2'd1:    return 1'b0;
            2'd2:    return !neg && nz;
            default: return neg && nz;
        endcase
    endfunction

    task automatic model_i2f(input logic [31:0] a, input logic [1:0] rm);
        longint v, mag, q, rem, half;
        int L, k, ex;
        bit neg, up;
        v   = longint'($signed(a));
        neg = v < 0;
        mag = neg ? -v : v;
        m_inv  = 1'b0;
        m_inex = 1'b0;
        if (mag == 0) begin
            m_data = 32'h0;
            m_tag  = "R2 R8";
            return;
        end
        L = 0;
        while ((mag >> L) != 0) L++;
        ex = 127 + L - 1;
        if (L > 24) begin
            k    = L - 24;
            q    = mag >> k;
            rem  = mag - (q << k);
            half = longint'(1) << (k - 1);
            up   = round_up(neg, q[0], rem > half, rem == half, rem != 0, rm);
            m_inex = rem != 0;
            q = q + (up ? 1 : 0);
            if (q == (longint'(1) << 24)) begin
                q  = q >> 1;
                ex = ex + 1;
            end
        end else begin
            q = mag << (24 - L);
        end
        m_data = {neg, 8'(ex), 23'(q)};
        m_tag  = m_inex ? "R3 R8" : "R2 R8";
    endtask

    task automatic model_f2i(input logic [31:0] a, input logic [1:0] rm);
        bit s;
        int ex, ee, sh;
        longint m, q, rem, half, magl, sv;
        bit gt, eq, nz, sat;
        s  = a[31];
        ex = int'(a[30:23]);
        m_inv  = 1'b0;
        m_inex = 1'b0;
        if (ex == 255) begin
            m_inv  = 1'b1;
            m_data = (a[22:0] != 0 || !s) ? 32'h7FFFFFFF : 32'h80000000;
            m_tag  = (a[22:0] != 0) ? "R5" : "R6";
            return;
        end
        m   = (ex == 0) ? longint'(a[22:0]) : longint'(a[22:0]) + (longint'(1) << 23);
        ee  = (ex == 0) ? 1 : ex;
        sat = 1'b0;
        magl = 0;
        if (ee >= 150) begin
            if (ee >= 190) sat = 1'b1;
            else magl = m << (ee - 150);
        end else begin
            sh = 150 - ee;
            if (sh >= 40) begin
                q = 0; gt = 0; eq = 0; nz = (m != 0);
            end else begin
                q    = m >> sh;
                rem  = m - (q << sh);
                half = longint'(1) << (sh - 1);
                gt   = rem > half;
                eq   = rem == half;
                nz   = rem != 0;
            end
            m_inex = nz;
            magl   = q + (round_up(s, q[0], gt, eq, nz, rm) ? 1 : 0);
        end
        sv = s ? -magl : magl;
        if (sat || sv > 64'sd2147483647 || sv < -64'sd2147483648) begin
            m_inv  = 1'b1;
            m_inex = 1'b0;
            m_data = s ? 32'h80000000 : 32'h7FFFFFFF;
            m_tag  = "R6";
        end else begin
            m_data = 32'(sv);
            m_tag  = (ex == 0) ? "R7" : (a == 32'hCF000000 ? "R6" : "R4");
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid = 1'b0;
            m_data  = 32'h0;
            m_inv   = 1'b0;
            m_inex  = 1'b0;
            m_tag   = "R1";
        end else begin
            m_valid = in_valid;
            if (in_valid) begin
                if (in_op == 1'b0) model_i2f(in_data, in_rm);
                else               model_f2i(in_data, in_rm);
            end else begin
                m_tag = "R1 R9";
            end
        end
    end

    always @(negedge clk) begin
        if (running && rst_n) begin
            checks++;
            if (out_valid !== m_valid || out_data !== m_data ||
                out_invalid !== m_inv || out_inexact !== m_inex) begin
                errors++;
                $display("FAIL %s: got v=%0b d=%08h inv=%0b inx=%0b, expected v=%0b d=%08h inv=%0b inx=%0b",
                         m_tag, out_valid, out_data, out_invalid, out_inexact,
                         m_valid, m_data, m_inv, m_inex);
            end
        end
    end

    task automatic drive(input logic op, input logic [1:0] rm, input logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b1;
        in_op    = op;
        in_rm    = rm;
        in_data  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic all_modes(input logic op, input logic [31:0] d);
        for (int r = 0; r < 4; r++) drive(op, 2'(r), d);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion before timeout");
        finish_run();
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_op    = 1'b0;
        in_rm    = 2'd0;
        in_data  = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_data !== 32'h0 || out_invalid !== 1'b0 || out_inexact !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got v=%0b d=%08h inv=%0b inx=%0b, expected all zero",
                     out_valid, out_data, out_invalid, out_inexact);
        end
        rst_n   = 1'b1;
        running = 1'b1;
        idle(2);

        // R2: exact integer conversions
        drive(1'b0, 2'd0, 32'h0);
        drive(1'b0, 2'd0, 32'h1);
        drive(1'b0, 2'd0, 32'hFFFFFFFF);
        drive(1'b0, 2'd1, 32'd16777216);
        idle(2);
        // R3: rounding at the 24-bit boundary, all codes
        all_modes(1'b0, 32'd16777217);
        all_modes(1'b0, 32'd16777219);
        all_modes(1'b0, 32'h7FFFFFFF);
        all_modes(1'b0, 32'h80000000);
        all_modes(1'b0, -32'sd16777217);
        all_modes(1'b0, -32'sd16777219);
        idle(3);
        // R4: in-range fractional floats
        all_modes(1'b1, 32'h3FC00000);
        all_modes(1'b1, 32'h40200000);
        all_modes(1'b1, 32'hC0200000);
        all_modes(1'b1, 32'hBFC00000);
        all_modes(1'b1, 32'h3F000000);
        all_modes(1'b1, 32'h3F400000);
        drive(1'b1, 2'd0, 32'h4EFFFFFF);
        idle(1);
        // R5: NaNs
        drive(1'b1, 2'd0, 32'h7FC00000);
        drive(1'b1, 2'd3, 32'hFFC00000);
        drive(1'b1, 2'd1, 32'h7F800001);
        idle(2);
        // R6: saturation and the exact minimum
        drive(1'b1, 2'd0, 32'h7F800000);
        drive(1'b1, 2'd0, 32'hFF800000);
        drive(1'b1, 2'd2, 32'h4F000000);
        drive(1'b1, 2'd0, 32'hCF000000);
        drive(1'b1, 2'd3, 32'hCF000001);
        drive(1'b1, 2'd1, 32'h7F7FFFFF);
        idle(2);
        // R7: zeros and subnormals
        all_modes(1'b1, 32'h00000001);
        all_modes(1'b1, 32'h80000001);
        all_modes(1'b1, 32'h007FFFFF);
        drive(1'b1, 2'd2, 32'h00000000);
        drive(1'b1, 2'd3, 32'h80000000);
        idle(4);

        // Mixed pseudo-random traffic with gaps (R9 in the gaps)
        for (int n = 0; n < 1200; n++) begin
            logic [31:0] d;
            d = $urandom();
            if (n % 5 == 0) d = {d[31], 8'd120 + 8'(d[7:0] % 40), d[22:0]};
            drive(1'(n % 2), 2'($urandom() % 4), d);
            if (($urandom() % 4) == 0) idle(1 + int'($urandom() % 3));
        end
        idle(4);
        running = 1'b0;
        finish_run();
    end

endmodule